// File: doc/BRIEF.md
# Load Value Replay Checker

This block checks whether a load that ran early, out of program order, still returned a value that holds at commit. The check is made on the value, not the address. The execute stage hands over each speculative load's tag, address and returned data as the load completes. The block keeps these in a small buffer, oldest first. When the commit stage asks to retire the oldest load, the block reads that address again through a single-port memory interface and compares the fresh value with the stored one.

If the two values are equal, the load retires and a one-cycle done pulse goes back to the commit stage. If they differ, some other agent wrote the location in between, and the early result cannot be trusted. The block then drops every buffered load and raises a squash, carrying the tag of the load that failed, so that the pipeline can re-execute from that point. While a replay read is outstanding, the block holds commit back. Stores are not tracked here, because they issue in order at commit.

Top module: `lvr_checker`

## Requirements
- R1: A capture with `cap_valid` high stores the tag, address and data when fewer than DEPTH (default 8) loads are held. Loads are kept in arrival order, and arrival order is age order. `cap_full` is high while DEPTH loads are held, and a capture made while full is dropped.
- R2: A commit request (`cmt_valid` high) seen while the block is idle and holds at least one load raises `mem_req_valid` in the next cycle. `mem_req_addr` then carries the address of the oldest held load.
- R3: Once raised, `mem_req_valid` stays high with `mem_req_addr` unchanged until a cycle in which `mem_req_ready` is high.
- R4: `cmt_stall` is high from the cycle after a commit request is accepted until the cycle in which the result appears. It falls only together with `cmt_done` or `squash_valid`.
- R5: The first `mem_rsp_valid` after the request completes the replay. If `mem_rsp_data` equals the stored data, `cmt_done` is high for exactly one cycle, in the cycle after the response, and the oldest load leaves the buffer.
- R6: If the replayed data differs from the stored data, `squash_valid` is high for exactly one cycle, in the cycle after the response, and `squash_tag` carries the failing load's tag. All held loads, the failing one and every younger one, are discarded.
- R7: A commit request is ignored if it arrives while the buffer is empty or while a replay is in progress. It starts no memory read and produces no result.
- R8: A `mem_rsp_valid` that arrives while no replay read is outstanding is ignored and changes no held load.
- R9: After reset the buffer is empty, and `cap_full`, `cmt_stall`, `cmt_done`, `squash_valid` and `mem_req_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_valid | input | 1 | Execute stage delivers a speculative load result |
| cap_tag | input | TAG_W (4) | Tag of the captured load |
| cap_addr | input | ADDR_W (32) | Address of the captured load |
| cap_data | input | DATA_W (32) | Value the load returned at execute |
| cap_full | output | 1 | Buffer holds DEPTH loads |
| cmt_valid | input | 1 | Commit stage asks to retire the oldest load |
| cmt_stall | output | 1 | Replay in progress, commit must wait |
| cmt_done | output | 1 | One-cycle pulse: oldest load verified and retired |
| mem_req_valid | output | 1 | Replay read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W (32) | Replay read address |
| mem_rsp_valid | input | 1 | Replay read data is valid |
| mem_rsp_data | input | DATA_W (32) | Replay read data |
| squash_valid | output | 1 | One-cycle pulse: value mismatch, pipeline must squash |
| squash_tag | output | TAG_W (4) | Tag of the load that failed the replay |

## Verification
Several properties are checked on every cycle. The read request stays steady under backpressure. The done and squash pulses last one cycle each and never coincide. Commit stalls release only together with a result. A squash leaves the buffer empty, the occupancy never exceeds its depth, and an empty-buffer commit never raises a memory request. Other behaviour shows only in the bench's scenarios, where a scoreboard holds its own model of the buffer. These cover which load is replayed, in age order, and whether each verdict is right. They also cover that a squash carries the right tag and discards the younger loads, that a capture made while full is dropped, and that a stray response leaves the buffered data untouched.

// File: rtl/lvr_pkg.sv
`timescale 1ns/1ps
package lvr_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int TAG_W  = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;

    // One speculative load held for replay
    typedef struct packed {
        tag_t  tag;
        addr_t addr;
        data_t data;
    } ld_entry_t;

    typedef enum logic [1:0] {
        RP_IDLE  = 2'd0,
        RP_ISSUE = 2'd1,
        RP_WAIT  = 2'd2
    } rp_state_e;

    typedef enum logic [1:0] {
        VR_NONE = 2'd0,
        VR_PASS = 2'd1,
        VR_FAIL = 2'd2
    } verdict_e;

    // Verdict on a replayed load: no verdict unless a response is being consumed
    function automatic verdict_e judge(input logic seen, input data_t early, input data_t late);
        if (!seen)
            return VR_NONE;
        else if (early == late)
            return VR_PASS;
        else
            return VR_FAIL;
    endfunction

endpackage

// File: rtl/lvr_store.sv
`timescale 1ns/1ps
module lvr_store
    import lvr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  ld_entry_t push_entry,
    input  logic      pop,
    input  logic      flush,
    output ld_entry_t head,
    output logic      empty,
    output logic      full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    ld_entry_t        slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             push_ok, pop_ok;
    logic [DEPTH-1:0] slot_we;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (count_q == '0);
    assign full    = (count_q == FULL_CNT);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = slot_q[rd_ptr_q];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot_we
        assign slot_we[i] = push_ok && (wr_ptr_q == PTR_W'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i])
                slot_q[i] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok)
                wr_ptr_q <= bump(wr_ptr_q);
            if (pop_ok)
                rd_ptr_q <= bump(rd_ptr_q);
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // R1
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL_CNT);

    // R6
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

    // R1
    full_push_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/lvr_seq.sv
`timescale 1ns/1ps
module lvr_seq
    import lvr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmt_valid,
    input  logic      empty,
    input  ld_entry_t head,
    input  logic      mem_req_ready,
    input  logic      mem_rsp_valid,
    input  data_t     mem_rsp_data,
    output logic      mem_req_valid,
    output addr_t     mem_req_addr,
    output logic      cmt_stall,
    output logic      pop,
    output logic      flush,
    output logic      cmt_done,
    output logic      squash_valid,
    output tag_t      squash_tag
);

    rp_state_e st_q;
    verdict_e  verdict;
    logic      done_q, sq_q;
    tag_t      sq_tag_q;

    assign verdict       = judge(st_q == RP_WAIT && mem_rsp_valid, head.data, mem_rsp_data);
    assign pop           = (verdict == VR_PASS);
    assign flush         = (verdict == VR_FAIL);
    assign mem_req_valid = (st_q == RP_ISSUE);
    assign mem_req_addr  = head.addr;
    assign cmt_stall     = (st_q != RP_IDLE);
    assign cmt_done      = done_q;
    assign squash_valid  = sq_q;
    assign squash_tag    = sq_tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= RP_IDLE;
            done_q   <= 1'b0;
            sq_q     <= 1'b0;
            sq_tag_q <= '0;
        end else begin
            done_q <= 1'b0;
            sq_q   <= 1'b0;
            case (st_q)
                RP_IDLE: begin
                    if (cmt_valid && !empty)
                        st_q <= RP_ISSUE;
                end
                RP_ISSUE: begin
                    if (mem_req_ready)
                        st_q <= RP_WAIT;
                end
                RP_WAIT: begin
                    if (verdict == VR_PASS) begin
                        done_q <= 1'b1;
                        st_q   <= RP_IDLE;
                    end else if (verdict == VR_FAIL) begin
                        sq_q     <= 1'b1;
                        sq_tag_q <= head.tag;
                        st_q     <= RP_IDLE;
                    end
                end
                default: st_q <= RP_IDLE;
            endcase
        end
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4
    stall_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cmt_stall) |-> (cmt_done || squash_valid));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmt_done |=> !cmt_done);

    // R6
    squash_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> !squash_valid);

    // R5
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmt_done && squash_valid));

endmodule

// File: rtl/lvr_checker.sv
`timescale 1ns/1ps
module lvr_checker
    import lvr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_valid,
    input  logic [TAG_W-1:0]  cap_tag,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    output logic              cap_full,
    input  logic              cmt_valid,
    output logic              cmt_stall,
    output logic              cmt_done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              squash_valid,
    output logic [TAG_W-1:0]  squash_tag
);

    ld_entry_t cap_entry, head;
    logic      buf_empty, buf_full, pop, flush;

    assign cap_entry = '{tag: cap_tag, addr: cap_addr, data: cap_data};
    assign cap_full  = buf_full;

    lvr_store #(.DEPTH(DEPTH)) store_i (
        .clk        (clk),
        .rst        (rst),
        .push       (cap_valid),
        .push_entry (cap_entry),
        .pop        (pop),
        .flush      (flush),
        .head       (head),
        .empty      (buf_empty),
        .full       (buf_full)
    );

    lvr_seq seq_i (
        .clk           (clk),
        .rst           (rst),
        .cmt_valid     (cmt_valid),
        .empty         (buf_empty),
        .head          (head),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .cmt_stall     (cmt_stall),
        .pop           (pop),
        .flush         (flush),
        .cmt_done      (cmt_done),
        .squash_valid  (squash_valid),
        .squash_tag    (squash_tag)
    );

    // R6
    squash_empties_chk: assert property (@(posedge clk) disable iff (rst)
        squash_valid |-> buf_empty);

    // R7
    empty_commit_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && buf_empty && !cmt_stall) |=> !mem_req_valid);

    // R2
    commit_starts_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && !buf_empty && !cmt_stall) |=> mem_req_valid);

endmodule

// File: tb/lvr_checker_tb_top.sv
`timescale 1ns/1ps
module lvr_checker_tb_top;
    import lvr_pkg::*;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cap_valid;
    tag_t        cap_tag;
    addr_t       cap_addr;
    data_t       cap_data;
    logic        cap_full;
    logic        cmt_valid;
    logic        cmt_stall;
    logic        cmt_done;
    logic        mem_req_valid;
    logic        mem_req_ready;
    addr_t       mem_req_addr;
    logic        mem_rsp_valid;
    data_t       mem_rsp_data;
    logic        squash_valid;
    tag_t        squash_tag;

    always #2.5 clk = ~clk;

    lvr_checker #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .cap_valid(cap_valid), .cap_tag(cap_tag), .cap_addr(cap_addr), .cap_data(cap_data),
        .cap_full(cap_full),
        .cmt_valid(cmt_valid), .cmt_stall(cmt_stall), .cmt_done(cmt_done),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .squash_valid(squash_valid), .squash_tag(squash_tag)
    );

    // ---------------- memory model ----------------
    data_t mem [16];
    int    lat;
    logic  pend;
    int    pcnt;
    addr_t paddr;
    logic  m_rsp_valid;
    data_t m_rsp_data;
    logic  stray_v;
    data_t stray_d;

    assign mem_rsp_valid = m_rsp_valid | stray_v;
    assign mem_rsp_data  = stray_v ? stray_d : m_rsp_data;

    always @(posedge clk) begin
        if (rst) begin
            pend        <= 1'b0;
            m_rsp_valid <= 1'b0;
            m_rsp_data  <= '0;
            pcnt        <= 0;
            paddr       <= '0;
        end else begin
            m_rsp_valid <= 1'b0;
            if (pend) begin
                if (pcnt == 0) begin
                    m_rsp_valid <= 1'b1;
                    m_rsp_data  <= mem[paddr[5:2]];
                    pend        <= 1'b0;
                end else begin
                    pcnt <= pcnt - 1;
                end
            end else if (mem_req_valid && mem_req_ready) begin
                pend  <= 1'b1;
                pcnt  <= lat;
                paddr <= mem_req_addr;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit   fail;
        tag_t tag;
    } exp_t;

    exp_t      expq [$];
    ld_entry_t model [$];
    int        n_checks = 0;
    int        n_fail   = 0;
    bit        finished = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected verdicts as the design produces them
    always @(negedge clk) begin
        if (!rst && (cmt_done || squash_valid)) begin
            if (expq.size() == 0) begin
                check(0, "R7 unexpected verdict", {cmt_done, squash_valid}, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.fail) begin
                    check(squash_valid && !cmt_done, "R6 squash expected", {cmt_done, squash_valid}, 1);
                    check(squash_tag == e.tag, "R6 squash tag", squash_tag, e.tag);
                end else begin
                    check(cmt_done && !squash_valid, "R5 done expected", {cmt_done, squash_valid}, 2);
                end
            end
        end
    end

    task automatic capture(input tag_t t, input int idx, input data_t d);
        @(negedge clk);
        cap_valid = 1'b1;
        cap_tag   = t;
        cap_addr  = addr_t'(idx * 4);
        cap_data  = d;
        if (model.size() < DEPTH)
            model.push_back('{tag: t, addr: addr_t'(idx * 4), data: d});
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    // hold > 0: keep memory not ready for that many cycles, with a second commit request inside
    task automatic commit(input int hold);
        @(negedge clk);
        if (model.size() == 0) begin
            cmt_valid = 1'b1;
            @(negedge clk);
            cmt_valid = 1'b0;
            for (int i = 0; i < 4; i++) begin
                check(!mem_req_valid && !cmt_stall, "R7 empty commit ignored", {mem_req_valid, cmt_stall}, 0);
                @(negedge clk);
            end
        end else begin
            ld_entry_t h;
            exp_t      e;
            int        w;
            h      = model[0];
            e.fail = (mem[h.addr[5:2]] != h.data);
            e.tag  = h.tag;
            expq.push_back(e);
            if (e.fail) model.delete();
            else void'(model.pop_front());
            if (hold > 0) mem_req_ready = 1'b0;
            cmt_valid = 1'b1;
            @(negedge clk);
            cmt_valid = 1'b0;
            check(cmt_stall, "R4 stall after commit", cmt_stall, 1);
            check(mem_req_valid, "R2 request raised", mem_req_valid, 1);
            check(mem_req_addr == h.addr, "R2 oldest address", mem_req_addr, h.addr);
            for (int i = 0; i < hold; i++) begin
                if (i == 1) cmt_valid = 1'b1;
                @(negedge clk);
                cmt_valid = 1'b0;
                check(mem_req_valid && mem_req_addr == h.addr, "R3 request held", mem_req_addr, h.addr);
            end
            mem_req_ready = 1'b1;
            w = 0;
            while (!(cmt_done || squash_valid) && w < 64) begin
                check(cmt_stall, "R4 stall while replaying", cmt_stall, 1);
                @(negedge clk);
                w++;
            end
            check(w < 64, "R5 verdict arrives", w, 0);
            check(!cmt_stall, "R4 stall released with verdict", cmt_stall, 0);
            @(negedge clk);
            check(!cmt_done && !squash_valid, "R5 R6 one-cycle verdict", {cmt_done, squash_valid}, 0);
            if (hold > 0) begin
                for (int i = 0; i < 3; i++) begin
                    check(!mem_req_valid, "R7 commit during replay ignored", mem_req_valid, 0);
                    @(negedge clk);
                end
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cap_valid = 0; cap_tag = '0; cap_addr = '0; cap_data = '0;
        cmt_valid = 0; mem_req_ready = 1'b1; lat = 0;
        stray_v = 0; stray_d = '0;
        for (int i = 0; i < 16; i++) mem[i] = 32'h1000 + i;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        check(!cap_full && !cmt_stall && !cmt_done && !squash_valid && !mem_req_valid,
              "R9 reset outputs", {cap_full, cmt_stall, cmt_done, squash_valid, mem_req_valid}, 0);

        // R7 commit with nothing buffered
        commit(0);

        // R1 R2 R5 age order, varied latency
        capture(4'd1, 0, 32'h1000);
        capture(4'd2, 1, 32'h1001);
        capture(4'd3, 2, 32'h1002);
        lat = 0; commit(0);
        lat = 2; commit(0);
        lat = 5; commit(0);
        lat = 1;

        // R3 R7 backpressure with a second commit request during replay
        capture(4'd4, 3, 32'h1003);
        commit(4);

        // R8 stray response while idle
        capture(4'd5, 4, 32'h1004);
        @(negedge clk);
        stray_v = 1'b1; stray_d = 32'hDEAD_BEEF;
        @(negedge clk);
        stray_v = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(!cmt_done && !squash_valid, "R8 stray response ignored", {cmt_done, squash_valid}, 0);
            @(negedge clk);
        end
        commit(0);

        // R6 mismatch in the middle, younger discarded
        capture(4'd6, 5, 32'h1005);
        capture(4'd7, 6, 32'h1006);
        capture(4'd8, 7, 32'h1007);
        mem[6] = 32'h5555_0006;
        commit(0);
        commit(0);
        check(!cap_full, "R6 buffer emptied", cap_full, 0);
        commit(0);
        mem[6] = 32'h1006;

        // R1 fill to capacity, overflow capture dropped
        for (int i = 0; i < DEPTH; i++) capture(tag_t'(i + 8), i, 32'h1000 + i);
        @(negedge clk);
        check(cap_full, "R1 full after DEPTH captures", cap_full, 1);
        capture(4'd15, 9, 32'h2222_0000);
        check(cap_full, "R1 still full", cap_full, 1);
        for (int i = 0; i < DEPTH; i++) commit(0);
        check(!cap_full, "R1 drained", cap_full, 0);
        commit(0);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R5 all verdicts seen", expq.size(), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule